// File: doc/BRIEF.md
# Constant-Schedule Modular Inverter

This block returns the multiplicative inverse of an operand modulo an odd prime. It raises the operand to the power p-2 and scans that exponent from its least significant bit upward. Each exponent bit costs two modular products. The first multiplies the running result by the current base. When the bit is 0, that product is still computed but is written to a scratch register that nothing reads. The second product squares the base. Every input therefore follows the same schedule of products, and the run time does not depend on the operand or on the modulus.

The products come from one bit-serial multiplier. It scans the multiplier operand from its most significant bit downward. On each cycle it doubles the partial product, reduces it, adds the other operand when the scanned bit is set, and reduces again. A caller pulses `start` with `a` and `p` valid. `busy` stays high for the whole run. `done` pulses for one cycle when `result` and `zero_err` are updated. The caller must supply a prime `p` with 3 <= p < 2^WIDTH and an operand `a` with a < p.

Top module: `fermat_inv`

## Requirements
- R1: For a prime p and 0 < a < p, `result` equals a^(p-2) mod p when `done` pulses, and it is always below p.
- R2: For a prime p and 0 < a < p, (a * result) mod p equals 1.
- R3: `done` rises exactly 2*WIDTH*WIDTH clock edges after the edge that accepts `start`, for every a and p, including a = 0.
- R4: `busy` is high from the cycle after an accepted start up to the cycle before `done`. It is low while `done` is high. `done` lasts exactly one cycle.
- R5: For a = 0, `result` is 0 and `zero_err` is 1 when `done` pulses. For any nonzero a, `zero_err` is 0.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The current run finishes with the result for its original operands.
- R7: `result` and `zero_err` keep their values from one `done` pulse until the next.
- R8: After reset, `busy`, `done`, `result` and `zero_err` are all 0.
- R9: While a run is in progress, the partial product, the running result, the base and the scratch register all stay below p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| a | input | WIDTH | Operand to invert, must be below p |
| p | input | WIDTH | Odd prime modulus |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | WIDTH | The inverse, held until the next done |
| zero_err | output | 1 | The operand of the last run was zero |

## Verification
The bench drives the extreme operands 1 and p-1, the smallest prime 3, and the largest 16-bit prime. A design that lost the final reduction in its multiplier would return values at or above p for these operands. A design that left out the dummy product would finish early whenever the exponent has zero bits, and the exact cycle count catches that. A zero operand has to run for the full time and raise the flag; a design that exits early on zero, or leaves a stale result in place, fails this check. A second start pulse in the middle of a run tests whether the operands get reloaded; if they do, the result corresponds to the wrong operand.

// File: rtl/fermat_inv.sv
module fermat_inv #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] p,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             zero_err
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] pm, ex, r1, r2, r3, acc;
  logic [CW-1:0]    mcnt, bidx;
  logic             sq, zflag;

  // one step of the bit-serial product: acc = 2*acc + bit*x, kept below p
  logic [CW-1:0]    yidx;
  logic [WIDTH-1:0] x, dblr, nxt;
  logic [WIDTH:0]   dbl, sum, pw;
  logic             ybit;

  assign pw   = {1'b0, pm};
  assign yidx = LAST - mcnt;
  assign ybit = r2[yidx];
  assign x    = sq ? r2 : r1;
  assign dbl  = {acc, 1'b0};
  assign dblr = (dbl >= pw) ? WIDTH'(dbl - pw) : dbl[WIDTH-1:0];
  assign sum  = {1'b0, dblr} + {1'b0, (ybit ? x : '0)};
  assign nxt  = (sum >= pw) ? WIDTH'(sum - pw) : sum[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm <= '0; ex <= '0; r1 <= '0; r2 <= '0; r3 <= '0; acc <= '0;
      mcnt <= '0; bidx <= '0; sq <= 1'b0; zflag <= 1'b0;
      busy <= 1'b0; done <= 1'b0; result <= '0; zero_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        pm    <= p;
        ex    <= p - WIDTH'(2);
        r1    <= WIDTH'(1);
        r2    <= a;
        r3    <= '0;
        acc   <= '0;
        mcnt  <= '0;
        bidx  <= '0;
        sq    <= 1'b0;
        zflag <= (a == '0);
        busy  <= 1'b1;
      end else if (busy) begin
        if (mcnt == LAST) begin
          acc  <= '0;
          mcnt <= '0;
          if (!sq) begin
            if (ex[bidx]) r1 <= nxt;
            else          r3 <= nxt;
            sq <= 1'b1;
          end else begin
            r2 <= nxt;
            sq <= 1'b0;
            if (bidx == LAST) begin
              busy     <= 1'b0;
              done     <= 1'b1;
              result   <= r1;
              zero_err <= zflag;
            end else begin
              bidx <= bidx + CW'(1);
            end
          end
        end else begin
          acc  <= nxt;
          mcnt <= mcnt + CW'(1);
        end
      end
    end
  end

  assert_run_ends_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_operands_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ex) && $stable(pm)));
  assert_zero_gives_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_err) |-> (result == '0));
  assert_result_reduced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < pm));
  assert_state_reduced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (acc < pm && r1 < pm && r2 < pm && r3 < pm));
endmodule

// File: tb/tb_fermat_inv.sv
module tb_fermat_inv;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2 * W * W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] a = '0, p = '0;
  logic busy, done, zero_err;
  logic [W-1:0] result;

  int checks = 0, fails = 0;
  longint cyc = 0;

  fermat_inv #(.WIDTH(W)) dut (.clk(clk), .rst_n(rst_n), .start(start), .a(a), .p(p),
    .busy(busy), .done(done), .result(result), .zero_err(zero_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint modpow(longint b, longint e, longint m);
    longint r = 1;
    b = b % m;
    while (e > 0) begin
      if (e[0]) r = (r * b) % m;
      b = (b * b) % m;
      e = e >> 1;
    end
    return r;
  endfunction

  function automatic bit is_prime(int n);
    if (n < 2) return 0;
    for (int d = 2; d * d <= n; d++) if (n % d == 0) return 0;
    return 1;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_op(int av, int pv, bit inject);
    int n = 0;
    bit stray = 0;
    @(negedge clk);
    a = W'(av); p = W'(pv); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R4 busy after start", busy, 1);
    while (n < 3 * LAT) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) break;
      if (!busy) stray = 1;
      if (inject && n == 37) begin start = 1'b1; a = W'((av + 1) % pv); p = W'(pv); end
      if (inject && n == 38) start = 1'b0;
    end
    chk("R3 latency", n, LAT);
    chk("R4 busy held", stray, 0);
    chk("R4 busy low at done", busy, 0);
    if (av == 0) begin
      chk("R5 zero result", result, 0);
      chk("R5 zero flag", zero_err, 1);
    end else begin
      chk(inject ? "R6 restart ignored" : "R1 inverse", result, modpow(av, pv - 2, pv));
      chk("R2 a*inv mod p", (longint'(av) * result) % pv, 1);
      chk("R5 flag clear", zero_err, 0);
    end
    begin
      logic [W-1:0] held = result;
      logic hz = zero_err;
      @(negedge clk);
      chk("R4 done one cycle", done, 0);
      repeat (3) @(negedge clk);
      chk("R7 result held", result, held);
      chk("R7 flag held", zero_err, hz);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int pv, av;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R8 busy reset", busy, 0);
    chk("R8 done reset", done, 0);
    chk("R8 result reset", result, 0);
    chk("R8 flag reset", zero_err, 0);
    rst_n = 1'b1;
    run_op(1, 65521, 0);
    run_op(65520, 65521, 0);
    run_op(1, 3, 0);
    run_op(2, 3, 0);
    run_op(0, 65521, 0);
    run_op(12345, 65521, 0);
    run_op(0, 7, 0);
    run_op(100, 257, 1);
    for (int i = 0; i < 40; i++) begin
      do pv = int'($urandom_range(65535, 3)); while (!is_prime(pv));
      av = (i % 10 == 9) ? 0 : int'($urandom_range(pv - 1, 1));
      run_op(av, pv, i % 13 == 5);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule